// File: doc/BRIEF.md
# Non-DMA Byte Transfer Handshake

This block paces programmed-I/O data movement between a host processor and the data path of a disk controller while a command executes without DMA. Whenever the data path has bytes for the host to take (read commands) or free room for bytes from the host (write commands), the block raises its interrupt. It sets the readiness and non-DMA execution status bits. It recognises a host access to the data register only when chip select, the data-register address and the right strobe are all present.

With the FIFO disabled, every single byte is requested on its own. With the FIFO enabled, a request starts once the data path's byte count reaches a programmable threshold. The request is then either held for the whole burst or dropped for one cycle after each byte. A programmable cycle window limits how long a request may wait for service. A miss is kept as a sticky overrun flag and is reported once the command has reached its result phase. The same interrupt line signals the end of execution, and the first result read clears it.

Top module: `pio_xfer_handshake`

## Requirements
- R1: After reset, irq, st_rqm, st_dio, st_nondma, ovr_err and host_xfer are all low and the block is idle.
- R2: With the FIFO disabled, during execution with dp_count nonzero, irq rises. In the cycle after a qualified transfer irq is low, and it stays low while dp_count is 0.
- R3: A transfer is recognised only during execution, on the rising edge of host_cs together with host_addr equal to 5 and the strobe matching the direction (host_rd when cmd_dir_rd is 1, host_wr when 0). Each such edge gives exactly one single-cycle host_xfer pulse, with host_xfer_rd showing which strobe caused it. Chip select alone, another address or the opposite strobe give no pulse and leave irq unchanged.
- R4: With the FIFO enabled, a data request starts only once dp_count is at least cfg_thresh. A count below the threshold raises no irq.
- R5: In burst mode (cfg_burst=1, FIFO enabled), irq stays high from the trigger through every transfer until the transfer of the last byte, after which it falls.
- R6: In non-burst mode (cfg_burst=0, FIFO enabled), irq is low for exactly one cycle after each transfer while bytes remain, then returns high.
- R7: st_rqm equals irq in every cycle.
- R8: If a data request waits more than cfg_svc_limit cycles without a transfer, a sticky overrun is recorded. ovr_err shows it only in the result phase. cmd_start clears it, and a transfer restarts the window.
- R9: exec_done during execution enters the result phase, raises irq, sets st_dio and clears st_nondma. The first qualified host_rd in the result phase clears irq without a host_xfer pulse.
- R10: st_nondma is high exactly while a data request is pending in execution. st_dio is high in execution of a read command and in the result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | 1: threshold-triggered FIFO requests; 0: per-byte requests |
| cfg_burst | input | 1 | 1: hold irq for a burst; 0: one-cycle gap per byte |
| cfg_thresh | input | CW | FIFO trigger level in bytes (0 treated as 1) |
| cfg_svc_limit | input | TW | Service window in cycles |
| cmd_dir_rd | input | 1 | 1: host reads data; 0: host writes data |
| cmd_start | input | 1 | Pulse: command execution begins |
| exec_done | input | 1 | Pulse: execution ends at the sector close |
| res_done | input | 1 | Pulse: result phase finished, return to idle |
| dp_count | input | CW | Bytes the host may move now (filled for read, free for write) |
| host_cs | input | 1 | Asynchronous chip select, active high |
| host_rd | input | 1 | Asynchronous read strobe, active high |
| host_wr | input | 1 | Asynchronous write strobe, active high |
| host_addr | input | AW | Register address; data register is 5 |
| host_xfer | output | 1 | Single-cycle pulse: one byte moved |
| host_xfer_rd | output | 1 | With host_xfer: 1 read, 0 write |
| irq | output | 1 | Shared interrupt: data request or end of execution |
| st_rqm | output | 1 | Status: ready for host |
| st_dio | output | 1 | Status: data direction toward host |
| st_nondma | output | 1 | Status: non-DMA data pending in execution |
| ovr_err | output | 1 | Overrun reported in the result phase |

## Verification
The overrun is the hardest case to reach: a request has to stay unserved for longer than the window while the command is still executing, and the flag must stay hidden until the result phase. The stimulus sets a short window, leaves a byte pending well past it, and checks ovr_err first during execution and then after exec_done. A second command with prompt service then shows that cmd_start cleared the flag. The one-cycle gap of non-burst mode is measured by sampling irq on every cycle of each access window.

// File: rtl/pio_pkg.sv
// Shared types for the non-DMA handshake block.
package pio_pkg;
    // Command phase as seen by the handshake.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXEC   = 2'd1,
        PH_RESULT = 2'd2
    } phase_t;
endpackage

// File: rtl/pio_strobe_qual.sv
// Synchronises the asynchronous host strobes and qualifies them.
// Assumes host_addr is stable while a strobe is active. Gives one
// single-cycle pulse per rising edge of (cs & address hit & strobe).
module pio_strobe_qual #(
    parameter int AW          = 3,
    parameter int DATA_ADDR   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    output logic          rd_hit_o,
    output logic          wr_hit_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] sync_q [SYNC_STAGES];
    logic [AW-1:0]   addr_q;
    logic            rd_prev_q;
    logic            wr_prev_q;
    logic            cs_s, rd_s, wr_s, addr_ok, rd_qual, wr_qual;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage captures the raw asynchronous strobes.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= '0;
                    else        sync_q[gi] <= {cs_i, rd_i, wr_i};
                end
            end else begin : g_next
                // Further stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= '0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Address is sampled once; it is held stable around the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_i;
    end

    assign cs_s    = sync_q[SYNC_STAGES-1][2];
    assign rd_s    = sync_q[SYNC_STAGES-1][1];
    assign wr_s    = sync_q[SYNC_STAGES-1][0];
    assign addr_ok = (addr_q == AW'(DATA_ADDR));
    assign rd_qual = cs_s & rd_s & addr_ok;
    assign wr_qual = cs_s & wr_s & addr_ok;

    // Remember last qualified level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b0;
            wr_prev_q <= 1'b0;
        end else begin
            rd_prev_q <= rd_qual;
            wr_prev_q <= wr_qual;
        end
    end

    assign rd_hit_o = rd_qual & ~rd_prev_q;
    assign wr_hit_o = wr_qual & ~wr_prev_q;
endmodule

// File: rtl/pio_req_gen.sv
// Produces the registered data-request level during execution.
// FIFO off: request while a byte is pending, masked the cycle after
// each transfer. FIFO on: a burst starts at the threshold and ends with
// the last byte; non-burst style masks one cycle after each transfer.
// Assumes dp_count reflects a transfer one cycle after the xfer pulse.
module pio_req_gen #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          fifo_en_i,
    input  logic          burst_en_i,
    input  logic [CW-1:0] thresh_i,
    input  logic [CW-1:0] count_i,
    input  logic          xfer_i,
    output logic          req_o
);
    logic          burst_q, burst_d;
    logic          req_q, req_d;
    logic [CW-1:0] eff_thr;
    logic          last_byte, gap_mask;

    assign eff_thr   = (thresh_i == '0) ? CW'(1) : thresh_i;
    assign last_byte = (count_i == CW'(1)) & xfer_i;
    assign gap_mask  = xfer_i & (~fifo_en_i | ~burst_en_i);

    // Next burst and request levels from count, mode and transfers.
    always_comb begin
        burst_d = 1'b0;
        if (active_i) begin
            if (!fifo_en_i) begin
                burst_d = (count_i != '0) & ~last_byte;
            end else if (!burst_q) begin
                burst_d = (count_i >= eff_thr) & ~last_byte;
            end else begin
                burst_d = (count_i != '0) & ~last_byte;
            end
        end
        req_d = burst_d & ~gap_mask;
    end

    // Hold the burst state and the request output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            burst_q <= burst_d;
            req_q   <= req_d;
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/pio_svc_timer.sv
// Measures how long a data request waits for service. The window
// restarts on a transfer or when the request drops. A wait longer than
// the limit sets a sticky overrun that only a new command clears.
module pio_svc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending_i,
    input  logic          xfer_i,
    input  logic [TW-1:0] limit_i,
    input  logic          clear_i,
    output logic          ovr_o
);
    logic [TW-1:0] cnt_q;
    logic          ovr_q;
    logic          expired;

    assign expired = pending_i & ~xfer_i & (cnt_q >= limit_i);

    // Count waiting cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!pending_i || xfer_i) cnt_q <= '0;
        else if (cnt_q < limit_i)     cnt_q <= cnt_q + TW'(1);
    end

    // Sticky overrun flag, cleared at command start.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (clear_i) ovr_q <= 1'b0;
        else if (expired) ovr_q <= 1'b1;
    end

    assign ovr_o = ovr_q;
endmodule

// File: rtl/pio_xfer_handshake.sv
// Top of the non-DMA byte handshake. Tracks the command phase, merges
// the data request and the end-of-execution event onto one interrupt,
// and drives the status bits. The command sequencer supplies the
// cmd_start / exec_done / res_done pulses and the data path supplies
// dp_count, updated one cycle after each host_xfer pulse.
module pio_xfer_handshake #(
    parameter int FIFO_DEPTH  = 16,
    parameter int TW          = 16,
    parameter int AW          = 3,
    parameter int DATA_ADDR   = 5,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic          cfg_burst,
    input  logic [CW-1:0] cfg_thresh,
    input  logic [TW-1:0] cfg_svc_limit,
    input  logic          cmd_dir_rd,
    input  logic          cmd_start,
    input  logic          exec_done,
    input  logic          res_done,
    input  logic [CW-1:0] dp_count,
    input  logic          host_cs,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    output logic          host_xfer,
    output logic          host_xfer_rd,
    output logic          irq,
    output logic          st_rqm,
    output logic          st_dio,
    output logic          st_nondma,
    output logic          ovr_err
);
    import pio_pkg::*;

    phase_t phase_q;
    logic   rd_hit, wr_hit;
    logic   in_exec, in_result;
    logic   req_data;
    logic   end_irq_q;
    logic   ovr_flag;

    pio_strobe_qual #(
        .AW(AW), .DATA_ADDR(DATA_ADDR), .SYNC_STAGES(SYNC_STAGES)
    ) i_strobe (
        .clk(clk), .rst_n(rst_n),
        .cs_i(host_cs), .rd_i(host_rd), .wr_i(host_wr), .addr_i(host_addr),
        .rd_hit_o(rd_hit), .wr_hit_o(wr_hit)
    );

    assign in_exec      = (phase_q == PH_EXEC);
    assign in_result    = (phase_q == PH_RESULT);
    assign host_xfer    = in_exec & (cmd_dir_rd ? rd_hit : wr_hit);
    assign host_xfer_rd = host_xfer & cmd_dir_rd;

    pio_req_gen #(.CW(CW)) i_req (
        .clk(clk), .rst_n(rst_n),
        .active_i(in_exec), .fifo_en_i(cfg_fifo_en), .burst_en_i(cfg_burst),
        .thresh_i(cfg_thresh), .count_i(dp_count), .xfer_i(host_xfer),
        .req_o(req_data)
    );

    pio_svc_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .pending_i(req_data & in_exec), .xfer_i(host_xfer),
        .limit_i(cfg_svc_limit), .clear_i(cmd_start & ~in_exec & ~in_result),
        .ovr_o(ovr_flag)
    );

    // Command phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (cmd_start) phase_q <= PH_EXEC;
                PH_EXEC:   if (exec_done) phase_q <= PH_RESULT;
                PH_RESULT: if (res_done)  phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // End-of-execution interrupt: set on exec_done, cleared by first result read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     end_irq_q <= 1'b0;
        else if (in_exec && exec_done)  end_irq_q <= 1'b1;
        else if (in_result && (rd_hit || res_done)) end_irq_q <= 1'b0;
    end

    assign irq       = (req_data & in_exec) | end_irq_q;
    assign st_rqm    = irq;
    assign st_nondma = req_data & in_exec;
    assign st_dio    = in_result | (in_exec & cmd_dir_rd);
    assign ovr_err   = in_result & ovr_flag;
endmodule

// File: rtl/pio_xfer_checker.sv
// Temporal checks on the handshake, attached to the top by bind.
module pio_xfer_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          burst,
    input logic          exec_now,
    input logic          exec_done,
    input logic          cmd_start,
    input logic          host_xfer,
    input logic          irq,
    input logic [CW-1:0] dp_count,
    input logic          st_dio,
    input logic          st_nondma,
    input logic          ovr_flag
);
    // R2: a transfer with FIFO off drops irq in the next cycle
    p_xfer_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && host_xfer && exec_now && !exec_done) |=> !irq);

    // R3: each qualified edge gives a single-cycle pulse
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_xfer |=> !host_xfer);

    // R5: burst mode holds irq while more than one byte remains
    p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && burst && exec_now && !exec_done && irq && host_xfer
         && dp_count > CW'(1)) |=> irq);

    // R6: non-burst mode gaps irq after each transfer
    p_nonburst_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !burst && exec_now && !exec_done && host_xfer) |=> !irq);

    // R8: overrun stays set until a new command
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !cmd_start) |=> ovr_flag);

    // R9: end of execution raises irq and switches status
    p_end_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && exec_done) |=> (irq && st_dio && !st_nondma));
endmodule

bind pio_xfer_handshake pio_xfer_checker #(.CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en), .burst(cfg_burst),
    .exec_now(in_exec), .exec_done(exec_done), .cmd_start(cmd_start),
    .host_xfer(host_xfer), .irq(irq), .dp_count(dp_count),
    .st_dio(st_dio), .st_nondma(st_nondma), .ovr_flag(ovr_flag)
);

// File: tb/test_pio_xfer_handshake.sv
module test_pio_xfer_handshake;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 5;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_fifo_en = 1'b0, cfg_burst = 1'b0;
    logic [CW-1:0] cfg_thresh = '0;
    logic [TW-1:0] cfg_svc_limit = 16'd200;
    logic          cmd_dir_rd = 1'b1, cmd_start = 1'b0, exec_done = 1'b0, res_done = 1'b0;
    logic [CW-1:0] dp_count = '0;
    logic          host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [2:0]    host_addr = 3'd0;
    logic          host_xfer, host_xfer_rd, irq, st_rqm, st_dio, st_nondma, ovr_err;

    logic          dp_load = 1'b0;
    logic [CW-1:0] dp_val = '0;
    int            n_chk = 0, n_fail = 0, low_cnt = 0;
    bit            exp_q[$];
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_xfer_handshake i_pio_xfer_handshake (.*);

    // Data path model: loads a count or takes one byte per transfer.
    always @(posedge clk) begin
        if (dp_load) dp_count <= dp_val;
        else if (host_xfer && dp_count != '0) dp_count <= dp_count - 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Monitor: every transfer pulse must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && host_xfer) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected host_xfer", 1, 0);
            else begin
                bit e;
                e = exp_q.pop_front();
                chk(host_xfer_rd == e, "R3 host_xfer_rd", int'(host_xfer_rd), int'(e));
            end
        end
        if (rst_n) chk(st_rqm == irq, "R7 st_rqm vs irq", int'(st_rqm), int'(irq));
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_dp(input int v);
        @(negedge clk); dp_val = CW'(v); dp_load = 1'b1;
        @(negedge clk); dp_load = 1'b0;
    endtask

    task automatic pulse_cmd(input int which);
        @(negedge clk);
        if (which == 0) cmd_start = 1'b1; else if (which == 1) exec_done = 1'b1; else res_done = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; exec_done = 1'b0; res_done = 1'b0;
    endtask

    // Driver: one host access; pushes the expected transfer if it qualifies.
    task automatic access(input bit cs, input bit rd, input bit wr, input int addr, input bit expect_x);
        @(negedge clk);
        if (expect_x) exp_q.push_back(rd);
        host_cs = cs; host_rd = rd; host_wr = wr; host_addr = 3'(addr);
        low_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); if (!irq) low_cnt++;
        end
        host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); if (!irq) low_cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk({irq, st_rqm, st_dio, st_nondma, ovr_err, host_xfer} == 6'b0, "R1 outputs in reset", 
            int'({irq, st_rqm, st_dio, st_nondma, ovr_err, host_xfer}), 0);
        rst_n = 1'b1;
        cyc(2);
        chk({irq, st_dio, st_nondma, ovr_err} == 4'b0, "R1 idle after reset",
            int'({irq, st_dio, st_nondma, ovr_err}), 0);

        // ---- FIFO off, read command ----
        cfg_fifo_en = 1'b0; cmd_dir_rd = 1'b1; cfg_svc_limit = 16'd200;
        pulse_cmd(0);
        cyc(2);
        chk(irq == 1'b0, "R2 no byte no irq", int'(irq), 0);
        chk(st_dio == 1'b1, "R10 dio in read exec", int'(st_dio), 1);
        set_dp(1); cyc(1);
        chk(irq == 1'b1, "R2 irq with byte pending", int'(irq), 1);
        chk(st_nondma == 1'b1, "R10 nondma while pending", int'(st_nondma), 1);
        access(1, 0, 0, 5, 0);
        chk(irq == 1'b1, "R3 cs alone ignored", int'(irq), 1);
        access(1, 1, 0, 2, 0);
        chk(irq == 1'b1, "R3 wrong address ignored", int'(irq), 1);
        access(1, 0, 1, 5, 0);
        chk(irq == 1'b1 && dp_count == 5'd1, "R3 opposite strobe ignored", int'(dp_count), 1);
        access(1, 1, 0, 5, 1);
        chk(irq == 1'b0, "R2 irq clear after transfer", int'(irq), 0);
        chk(dp_count == 5'd0, "R3 one byte taken", int'(dp_count), 0);
        set_dp(1); cyc(1);
        chk(irq == 1'b1, "R2 next byte requested", int'(irq), 1);
        access(1, 1, 0, 5, 1);
        chk(irq == 1'b0 && st_nondma == 1'b0, "R2 second byte cleared", int'(irq), 0);
        pulse_cmd(1);
        chk(irq && st_dio && !st_nondma, "R9 end irq and status",
            int'({irq, st_dio, st_nondma}), 6);
        chk(ovr_err == 1'b0, "R8 no overrun on prompt service", int'(ovr_err), 0);
        access(1, 1, 0, 5, 0);
        chk(irq == 1'b0, "R9 first result read clears irq", int'(irq), 0);
        pulse_cmd(2);

        // ---- FIFO on, burst, threshold 4 ----
        cfg_fifo_en = 1'b1; cfg_burst = 1'b1; cfg_thresh = 5'd4;
        pulse_cmd(0);
        set_dp(3); cyc(3);
        chk(irq == 1'b0, "R4 below threshold no irq", int'(irq), 0);
        set_dp(4); cyc(1);
        chk(irq == 1'b1, "R4 threshold reached irq", int'(irq), 1);
        for (int k = 0; k < 3; k++) begin
            access(1, 1, 0, 5, 1);
            chk(low_cnt == 0, "R5 burst keeps irq high", low_cnt, 0);
        end
        access(1, 1, 0, 5, 1);
        chk(irq == 1'b0, "R5 irq falls after last byte", int'(irq), 0);
        pulse_cmd(1); access(1, 1, 0, 5, 0); pulse_cmd(2);

        // ---- FIFO on, non-burst ----
        cfg_burst = 1'b0;
        pulse_cmd(0);
        set_dp(4); cyc(1);
        chk(irq == 1'b1, "R4 non-burst trigger", int'(irq), 1);
        for (int k = 0; k < 3; k++) begin
            access(1, 1, 0, 5, 1);
            chk(low_cnt == 1, "R6 one-cycle gap per byte", low_cnt, 1);
            chk(irq == 1'b1, "R6 irq back while bytes remain", int'(irq), 1);
        end
        access(1, 1, 0, 5, 1);
        chk(irq == 1'b0, "R6 irq low when empty", int'(irq), 0);
        pulse_cmd(1); access(1, 1, 0, 5, 0); pulse_cmd(2);

        // ---- write direction, burst, threshold 8 ----
        cmd_dir_rd = 1'b0; cfg_burst = 1'b1; cfg_thresh = 5'd8;
        pulse_cmd(0);
        cyc(1);
        chk(st_dio == 1'b0, "R10 dio low in write exec", int'(st_dio), 1'b0);
        set_dp(8); cyc(1);
        chk(irq == 1'b1, "R4 write burst trigger", int'(irq), 1);
        access(1, 1, 0, 5, 0);
        chk(dp_count == 5'd8, "R3 read ignored in write", int'(dp_count), 8);
        for (int k = 0; k < 8; k++) access(1, 0, 1, 5, 1);
        chk(irq == 1'b0 && dp_count == 5'd0, "R5 write burst done", int'(dp_count), 0);
        pulse_cmd(1); access(1, 1, 0, 5, 0); pulse_cmd(2);

        // ---- overrun ----
        cmd_dir_rd = 1'b1; cfg_fifo_en = 1'b0; cfg_svc_limit = 16'd20;
        pulse_cmd(0);
        set_dp(1); cyc(40);
        chk(ovr_err == 1'b0, "R8 overrun hidden during exec", int'(ovr_err), 0);
        access(1, 1, 0, 5, 1);
        pulse_cmd(1);
        chk(ovr_err == 1'b1, "R8 overrun reported in result", int'(ovr_err), 1);
        access(1, 1, 0, 5, 0);
        chk(ovr_err == 1'b1, "R8 overrun sticky in result", int'(ovr_err), 1);
        pulse_cmd(2);
        pulse_cmd(0);
        set_dp(1); cyc(1);
        access(1, 1, 0, 5, 1);
        pulse_cmd(1);
        chk(ovr_err == 1'b0, "R8 cleared by new command", int'(ovr_err), 0);
        access(1, 1, 0, 5, 0); pulse_cmd(2);

        cyc(4);
        chk(exp_q.size() == 0, "R3 all expected transfers seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule